// File: doc/BRIEF.md
# SCSI DMA Engine with Interrupt Gating

This block is a host-side DMA controller placed between a byte-wide SCSI bus controller and a word-wide system memory port. The host programs it through a small register file: a control/status register, a start address split into high and low halves, and a transfer count split the same way. Once enabled, the engine accepts or delivers bytes on the SCSI controller's request/acknowledge handshake. It pairs them into 16-bit memory accesses. It steps the address by two per word and counts a residual down by one per byte.

The enable bit has a second job. It is the only path by which the SCSI controller's interrupt reaches the host. The interrupt is also held back while a byte sits in the word buffer or while the residual is nonzero. To watch for reselection while the bus is idle, a driver clears the count and then sets enable: the engine stays idle and the interrupt passes through. Clearing enable halts the engine at the next word boundary. The address and residual then stay frozen so the host can read how far the transfer got. For an outbound transfer that stopped part-way, the residual reads one lower than the true number of bytes left.

Top module: `sdma_engine`

## Requirements
- R1: After reset the control register reads 0, `scsi_rst_n` is low, and `host_irq`, `scsi_dack` and `mem_req` are low.
- R2: Control bit 0 (FIFO run) and bit 1 (SCSI run) are active-low resets. While bit 0 is clear the engine does not move data and the error flags clear. `scsi_rst_n` follows bit 1.
- R3: Offsets 1/2 hold the high/low 16 bits of the start address, and offsets 3/4 hold those of the transfer count. They read back as written. Writing either count half also loads the residual (read at offsets 5/6), and the residual never exceeds the count.
- R4: With control bit 2 (send) clear and bit 3 (enable) set, the engine takes bytes from the SCSI side and then writes each word at the current address (`mem_we` high). The residual drops by 1 per byte and the address rises by 2 per word.
- R5: With send set, each word is first read from memory (`mem_we` low) and its bytes are then delivered to the SCSI side.
- R6: `host_irq` equals `scsi_irq` when enable is set, no byte is buffered and the residual is zero. It is low whenever enable is clear.
- R7: `host_irq` stays low while a byte is buffered or the residual is nonzero, even with enable set and `scsi_irq` high.
- R8: If enable is set with a nonzero residual and an odd start address, no data moves and status bit 5 (bus error) sets.
- R9: Writes to address or count while enable is set or the engine is busy are ignored and set status bit 4 (conflict).
- R10: Clearing enable stops the engine at the next word boundary (status bit 6, busy, falls). Address and residual then hold their values.
- R11: With send set, a residual that is nonzero and below the count reads as one less. A residual of zero, or one equal to the count, reads unchanged. With send clear it is never adjusted.
- R12: An odd count ends with a word that carries a single byte. The memory access count is the count rounded up to words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data appears on the next cycle |
| reg_off | input | 3 | Register offset |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Registered read data |
| scsi_irq | input | 1 | Interrupt from the SCSI controller |
| scsi_drq | input | 1 | Byte request from the SCSI controller |
| scsi_dack | output | 1 | Byte acknowledge; a byte moves when both are high |
| scsi_rst_n | output | 1 | Reset to the SCSI controller, from control bit 1 |
| mem_req | output | 1 | Memory word access request |
| mem_we | output | 1 | 1 = memory write (inbound), 0 = memory read |
| mem_addr | output | ADDR_W | Byte address of the word access |
| mem_ack | input | 1 | Memory access completes |
| host_irq | output | 1 | Gated interrupt to the host |

## Verification
Some properties are checked on every cycle. The gated interrupt is never high without enable and a raised `scsi_irq`, nor while the residual is nonzero or a byte is buffered. A running engine never holds an odd address. The count is frozen while busy, the residual stays within the count, and a FIFO reset clears both error flags on the next cycle. Other behaviour only the bench scenarios can show. These include byte and word totals for each count and direction, the memory address sequence, the halt point after enable is cleared, the off-by-one outbound residual against its unadjusted cases, and rejected writes that leave registers unchanged.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

   localparam int OFF_W = 3;

   localparam logic [OFF_W-1:0] OFF_CTRL    = 3'd0;
   localparam logic [OFF_W-1:0] OFF_ADDR_HI = 3'd1;
   localparam logic [OFF_W-1:0] OFF_ADDR_LO = 3'd2;
   localparam logic [OFF_W-1:0] OFF_CNT_HI  = 3'd3;
   localparam logic [OFF_W-1:0] OFF_CNT_LO  = 3'd4;
   localparam logic [OFF_W-1:0] OFF_RES_HI  = 3'd5;
   localparam logic [OFF_W-1:0] OFF_RES_LO  = 3'd6;

   // status bit positions above the writable control nibble
   localparam int SB_CONFLICT = 4;
   localparam int SB_BUSERR   = 5;
   localparam int SB_BUSY     = 6;

   // bit 0 fifo_run, bit 1 scsi_run, bit 2 send, bit 3 en
   typedef struct packed {
      logic en;
      logic send;
      logic scsi_run;
      logic fifo_run;
   } ctrl_t;

   typedef enum logic [1:0] {
      XS_IDLE  = 2'd0,
      XS_BYTE0 = 2'd1,
      XS_BYTE1 = 2'd2,
      XS_MEM   = 2'd3
   } xfer_state_e;

endpackage

// File: rtl/sdma_widen.sv
module sdma_widen #(
   parameter int IN_W  = 24,
   parameter int OUT_W = 32
) (
   input  logic [IN_W-1:0]  din,
   output logic [OUT_W-1:0] dout
);
   generate
      if (IN_W == OUT_W) begin : g_same
         assign dout = din;
      end else begin : g_pad
         assign dout = {{(OUT_W-IN_W){1'b0}}, din};
      end
   endgenerate
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
   import sdma_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wr,
   input  logic                reg_rd,
   input  logic [OFF_W-1:0]    reg_off,
   input  logic [REG_W-1:0]    reg_wdata,
   output logic [REG_W-1:0]    reg_rdata,
   output ctrl_t               ctrl,
   output logic                bus_err,
   output logic                conflict,
   output logic                ld_addr,
   output logic [ADDR_W-1:0]   ld_addr_val,
   output logic                ld_cnt,
   output logic [CNT_W-1:0]    ld_cnt_val,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [CNT_W-1:0]    count,
   input  logic [CNT_W-1:0]    resid,
   input  logic                busy
);
   localparam int WIDE_W = 2 * REG_W;

   logic [WIDE_W-1:0] addr_x, cnt_x, res_x, new_addr, new_cnt;
   logic [CNT_W-1:0]  resid_rep;
   logic              guarded, data_wr, hi_sel;
   logic [REG_W-1:0]  rd_mux;

   // outbound partial transfers report one byte fewer left
   always_comb begin
      resid_rep = resid;
      if (ctrl.send && resid != '0 && resid < count)
         resid_rep = resid - CNT_W'(1);
   end

   sdma_widen #(.IN_W(ADDR_W), .OUT_W(WIDE_W)) u_wa (.din(addr),      .dout(addr_x));
   sdma_widen #(.IN_W(CNT_W),  .OUT_W(WIDE_W)) u_wc (.din(count),     .dout(cnt_x));
   sdma_widen #(.IN_W(CNT_W),  .OUT_W(WIDE_W)) u_wr (.din(resid_rep), .dout(res_x));

   assign guarded = ctrl.en | busy;
   assign data_wr = reg_wr && (reg_off == OFF_ADDR_HI || reg_off == OFF_ADDR_LO ||
                               reg_off == OFF_CNT_HI  || reg_off == OFF_CNT_LO);
   assign hi_sel  = (reg_off == OFF_ADDR_HI) || (reg_off == OFF_CNT_HI);

   always_comb begin
      new_addr = addr_x;
      new_cnt  = cnt_x;
      if (hi_sel) begin
         new_addr[WIDE_W-1:REG_W] = reg_wdata;
         new_cnt[WIDE_W-1:REG_W]  = reg_wdata;
      end else begin
         new_addr[REG_W-1:0] = reg_wdata;
         new_cnt[REG_W-1:0]  = reg_wdata;
      end
   end

   assign ld_addr     = data_wr && !guarded &&
                        (reg_off == OFF_ADDR_HI || reg_off == OFF_ADDR_LO);
   assign ld_cnt      = data_wr && !guarded &&
                        (reg_off == OFF_CNT_HI || reg_off == OFF_CNT_LO);
   assign ld_addr_val = new_addr[ADDR_W-1:0];
   assign ld_cnt_val  = new_cnt[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl     <= '0;
         bus_err  <= 1'b0;
         conflict <= 1'b0;
      end else begin
         if (reg_wr && reg_off == OFF_CTRL)
            ctrl <= ctrl_t'(reg_wdata[3:0]);
         if (!ctrl.fifo_run) begin
            bus_err  <= 1'b0;
            conflict <= 1'b0;
         end else begin
            if (data_wr && guarded)
               conflict <= 1'b1;
            if (ctrl.en && !busy && resid != '0 && addr[0])
               bus_err <= 1'b1;
         end
      end
   end

   always_comb begin
      rd_mux = '0;
      case (reg_off)
         OFF_CTRL: begin
            rd_mux[3:0]         = ctrl;
            rd_mux[SB_CONFLICT] = conflict;
            rd_mux[SB_BUSERR]   = bus_err;
            rd_mux[SB_BUSY]     = busy;
         end
         OFF_ADDR_HI: rd_mux = addr_x[WIDE_W-1:REG_W];
         OFF_ADDR_LO: rd_mux = addr_x[REG_W-1:0];
         OFF_CNT_HI:  rd_mux = cnt_x[WIDE_W-1:REG_W];
         OFF_CNT_LO:  rd_mux = cnt_x[REG_W-1:0];
         OFF_RES_HI:  rd_mux = res_x[WIDE_W-1:REG_W];
         OFF_RES_LO:  rd_mux = res_x[REG_W-1:0];
         default:     rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   assert_flag_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl.fifo_run |=> (!bus_err && !conflict));

endmodule

// File: rtl/sdma_xfer.sv
module sdma_xfer
   import sdma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              send,
   input  logic              fifo_run,
   input  logic              bus_err,
   input  logic              ld_addr,
   input  logic [ADDR_W-1:0] ld_addr_val,
   input  logic              ld_cnt,
   input  logic [CNT_W-1:0]  ld_cnt_val,
   input  logic              scsi_drq,
   output logic              scsi_dack,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  count,
   output logic [CNT_W-1:0]  resid,
   output logic              busy,
   output logic              buffered
);
   xfer_state_e state;
   logic        dir_out;
   logic        go, last_byte;

   assign go        = en && fifo_run && !bus_err && resid != '0 && !addr[0];
   assign last_byte = (resid == CNT_W'(1));
   assign scsi_dack = (state == XS_BYTE0 || state == XS_BYTE1) && scsi_drq;
   assign mem_req   = (state == XS_MEM);
   assign mem_we    = !dir_out;
   assign mem_addr  = addr;
   assign busy      = (state != XS_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= XS_IDLE;
         dir_out  <= 1'b0;
         addr     <= '0;
         count    <= '0;
         resid    <= '0;
         buffered <= 1'b0;
      end else begin
         if (ld_addr) addr <= ld_addr_val;
         if (ld_cnt) begin
            count <= ld_cnt_val;
            resid <= ld_cnt_val;
         end
         if (!fifo_run) begin
            state    <= XS_IDLE;
            buffered <= 1'b0;
         end else begin
            unique case (state)
               XS_IDLE: if (go) begin
                  dir_out <= send;
                  state   <= send ? XS_MEM : XS_BYTE0;
               end
               XS_BYTE0: begin
                  if (scsi_dack) begin
                     resid <= resid - CNT_W'(1);
                     if (dir_out) begin
                        if (last_byte) begin
                           addr     <= addr + ADDR_W'(2);
                           buffered <= 1'b0;
                           state    <= XS_IDLE;
                        end else begin
                           state <= XS_BYTE1;
                        end
                     end else begin
                        buffered <= 1'b1;
                        state    <= last_byte ? XS_MEM : XS_BYTE1;
                     end
                  end else if (!dir_out && !en) begin
                     state <= XS_IDLE;  // inbound word not begun: boundary
                  end
               end
               XS_BYTE1: if (scsi_dack) begin
                  resid <= resid - CNT_W'(1);
                  if (dir_out) begin
                     addr     <= addr + ADDR_W'(2);
                     buffered <= 1'b0;
                     state    <= XS_IDLE;
                  end else begin
                     state <= XS_MEM;
                  end
               end
               XS_MEM: if (mem_ack) begin
                  if (dir_out) begin
                     buffered <= 1'b1;
                     state    <= XS_BYTE0;
                  end else begin
                     addr     <= addr + ADDR_W'(2);
                     buffered <= 1'b0;
                     state    <= XS_IDLE;
                  end
               end
               default: state <= XS_IDLE;
            endcase
         end
      end
   end

   assert_even_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !addr[0]);
   assert_cnt_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (count == $past(count)));
   assert_resid_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      resid <= count);
   assert_word_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_ack && mem_we && fifo_run) |=> (addr == $past(addr) + ADDR_W'(2)));

endmodule

// File: rtl/sdma_irq_gate.sv
module sdma_irq_gate (
   input  logic en,
   input  logic scsi_irq,
   input  logic buffered,
   input  logic resid_zero,
   output logic host_irq
);
   assign host_irq = scsi_irq && en && !buffered && resid_zero;
endmodule

// File: rtl/sdma_engine.sv
module sdma_engine
   import sdma_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [2:0]        reg_off,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   input  logic              scsi_irq,
   input  logic              scsi_drq,
   output logic              scsi_dack,
   output logic              scsi_rst_n,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   output logic              host_irq
);
   generate
      if (REG_W < 8) begin : g_bad_reg
         $error("REG_W must hold the control and status bits");
      end
      if (ADDR_W <= REG_W || ADDR_W > 2 * REG_W) begin : g_bad_addr
         $error("ADDR_W must fit a high/low register pair");
      end
      if (CNT_W <= REG_W || CNT_W > 2 * REG_W) begin : g_bad_cnt
         $error("CNT_W must fit a high/low register pair");
      end
   endgenerate

   ctrl_t             ctrl;
   logic              bus_err, conflict, busy, buffered;
   logic              ld_addr, ld_cnt;
   logic [ADDR_W-1:0] ld_addr_val, addr;
   logic [CNT_W-1:0]  ld_cnt_val, count, resid;

   sdma_regs #(.REG_W(REG_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ctrl(ctrl), .bus_err(bus_err), .conflict(conflict),
      .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
      .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
      .addr(addr), .count(count), .resid(resid), .busy(busy)
   );

   sdma_xfer #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_xfer (
      .clk(clk), .rst_n(rst_n),
      .en(ctrl.en), .send(ctrl.send), .fifo_run(ctrl.fifo_run), .bus_err(bus_err),
      .ld_addr(ld_addr), .ld_addr_val(ld_addr_val),
      .ld_cnt(ld_cnt), .ld_cnt_val(ld_cnt_val),
      .scsi_drq(scsi_drq), .scsi_dack(scsi_dack),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .addr(addr), .count(count), .resid(resid), .busy(busy), .buffered(buffered)
   );

   sdma_irq_gate u_gate (
      .en(ctrl.en), .scsi_irq(scsi_irq), .buffered(buffered),
      .resid_zero(resid == '0), .host_irq(host_irq)
   );

   assign scsi_rst_n = ctrl.scsi_run;

   assert_gate_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (ctrl.en && scsi_irq));
   assert_gate_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_irq |-> (resid == '0 && !buffered && !busy));

endmodule

// File: tb/sdma_engine_bench.sv
module sdma_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [2:0]  reg_off = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        scsi_irq = 1'b0;
   logic        scsi_drq, scsi_dack, scsi_rst_n;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr;
   logic        host_irq;

   int checks = 0, errors = 0;
   int granted = 0, consumed = 0;
   int bytes = 0, words = 0;
   logic        last_we = 1'b0;
   logic [31:0] last_maddr = '0;

   localparam logic [15:0] RUN = 16'h3, SEND = 16'h4, EN = 16'h8;

   always #5 clk = ~clk;
   assign mem_ack  = 1'b1;
   assign scsi_drq = (granted != consumed);

   sdma_engine u_sdma_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_off(reg_off),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scsi_irq(scsi_irq),
      .scsi_drq(scsi_drq), .scsi_dack(scsi_dack), .scsi_rst_n(scsi_rst_n),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
      .host_irq(host_irq)
   );

   always @(posedge clk) begin
      if (scsi_drq && scsi_dack) begin
         consumed <= consumed + 1;
         bytes    <= bytes + 1;
      end
      if (mem_req && mem_ack) begin
         words      <= words + 1;
         last_we    <= mem_we;
         last_maddr <= mem_addr;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] off, input logic [15:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_off = off; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] off, output logic [15:0] d);
      @(negedge clk); reg_rd = 1'b1; reg_off = off;
      @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic setup(input logic [15:0] c, input logic [15:0] a, input logic [15:0] cnt);
      wr(3'd0, c); wr(3'd1, 16'h0); wr(3'd2, a); wr(3'd3, 16'h0); wr(3'd4, cnt);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] d;
      int b0, w0;
      idle(3);
      // R1 reset state
      check("R1 scsi_rst_n", scsi_rst_n, 0);
      check("R1 host_irq", host_irq, 0);
      check("R1 dack/mem_req", {scsi_dack, mem_req}, 0);
      rst_n = 1'b1;
      idle(2);
      rd(3'd0, d); check("R1 ctrl", d, 0);

      // R2 scsi reset follows bit 1
      wr(3'd0, 16'h2); check("R2 scsi_rst_n high", scsi_rst_n, 1);
      wr(3'd0, 16'h0); check("R2 scsi_rst_n low", scsi_rst_n, 0);

      // R3 register pairs and residual load
      wr(3'd0, RUN);
      wr(3'd1, 16'h0012); wr(3'd2, 16'h3456); wr(3'd3, 16'h0001); wr(3'd4, 16'h0020);
      rd(3'd1, d); check("R3 addr hi", d, 16'h0012);
      rd(3'd2, d); check("R3 addr lo", d, 16'h3456);
      rd(3'd3, d); check("R3 cnt hi", d, 16'h0001);
      rd(3'd4, d); check("R3 cnt lo", d, 16'h0020);
      rd(3'd5, d); check("R3 resid hi", d, 16'h0001);
      rd(3'd6, d); check("R3 resid lo", d, 16'h0020);

      // R4 / R5 / R12 sweep over direction and count
      for (int dir = 0; dir < 2; dir++) begin
         for (int c = 1; c <= 6; c++) begin
            logic [15:0] a, ctl;
            int nw;
            a   = 16'h0100 + 16'(c * 32) + 16'(dir * 16'h400);
            ctl = RUN | (dir != 0 ? SEND : 16'h0);
            nw  = (c + 1) / 2;
            setup(ctl, a, 16'(c));
            b0 = bytes; w0 = words;
            granted = consumed + c;
            wr(3'd0, ctl | EN);
            idle(5 * c + 10);
            check(dir != 0 ? "R5 bytes" : "R4 bytes", 32'(bytes - b0), 32'(c));
            check("R12 words", 32'(words - w0), 32'(nw));
            check(dir != 0 ? "R5 mem_we" : "R4 mem_we", last_we, dir == 0);
            check("R4 last word addr", last_maddr, 32'(a) + 32'(2 * (nw - 1)));
            rd(3'd6, d); check("R11 resid done", d, 0);
            rd(3'd2, d); check("R4 end addr", d, a + 16'(2 * nw));
            wr(3'd0, ctl);
         end
      end

      // R11 untouched outbound residual reads unadjusted
      setup(RUN | SEND, 16'h0080, 16'd8);
      rd(3'd6, d); check("R11 resid untouched", d, 16'd8);

      // R6 gating sweep with zero count
      setup(RUN, 16'h0000, 16'h0000);
      for (int e = 0; e < 2; e++) begin
         for (int i = 0; i < 2; i++) begin
            wr(3'd0, RUN | (e != 0 ? EN : 16'h0));
            scsi_irq = (i != 0);
            #1;
            check("R6 host_irq", host_irq, 32'(e & i));
         end
      end
      scsi_irq = 1'b0;
      wr(3'd0, RUN);

      // R7 / R10 partial inbound
      setup(RUN, 16'h0200, 16'd10);
      granted = consumed + 5;
      wr(3'd0, RUN | EN);
      scsi_irq = 1'b1;
      idle(30);
      check("R7 irq held while buffered", host_irq, 0);
      rd(3'd6, d); check("R7 resid after 5", d, 16'd5);
      granted = consumed + 1;
      idle(10);
      check("R7 irq held nonzero resid", host_irq, 0);
      wr(3'd0, RUN);
      idle(5);
      rd(3'd0, d); check("R10 busy falls inbound", 32'(d[6]), 0);
      rd(3'd2, d); check("R10 addr inbound", d, 16'h0206);
      rd(3'd6, d); check("R11 inbound unadjusted", d, 16'd4);
      idle(10);
      rd(3'd2, d); check("R10 addr frozen", d, 16'h0206);
      scsi_irq = 1'b0;

      // R11 / R10 partial outbound
      setup(RUN | SEND, 16'h0300, 16'd10);
      granted = consumed + 4;
      wr(3'd0, RUN | SEND | EN);
      idle(40);
      rd(3'd0, d); check("R10 busy mid word", 32'(d[6]), 1);
      wr(3'd0, RUN | SEND);
      granted = consumed + 2;
      idle(10);
      rd(3'd0, d); check("R10 busy falls outbound", 32'(d[6]), 0);
      rd(3'd6, d); check("R11 outbound partial", d, 16'd3);
      rd(3'd2, d); check("R10 addr outbound", d, 16'h0306);
      rd(3'd4, d); check("R3 count kept", d, 16'd10);

      // R8 odd start address
      setup(RUN, 16'h0401, 16'd4);
      b0 = bytes; w0 = words;
      granted = consumed + 4;
      wr(3'd0, RUN | EN);
      idle(10);
      rd(3'd0, d); check("R8 bus error flag", 32'(d[5]), 1);
      check("R8 no bytes", 32'(bytes - b0), 0);
      check("R8 no words", 32'(words - w0), 0);
      rd(3'd6, d); check("R8 resid kept", d, 16'd4);
      wr(3'd0, 16'h0); wr(3'd0, RUN);
      rd(3'd0, d); check("R2 flags cleared", 32'(d[5]), 0);
      granted = consumed;

      // R9 write while enabled
      setup(RUN, 16'h0500, 16'h0000);
      wr(3'd0, RUN | EN);
      wr(3'd4, 16'd6);
      wr(3'd2, 16'h0700);
      rd(3'd4, d); check("R9 count unchanged", d, 16'd0);
      rd(3'd2, d); check("R9 addr unchanged", d, 16'h0500);
      rd(3'd0, d); check("R9 conflict flag", 32'(d[4]), 1);
      wr(3'd0, 16'h0);

      // R2 fifo reset holds the engine
      setup(16'h2, 16'h0600, 16'd4);
      b0 = bytes;
      granted = consumed + 4;
      wr(3'd0, 16'h2 | EN);
      idle(20);
      check("R2 no bytes in fifo reset", 32'(bytes - b0), 0);
      rd(3'd6, d); check("R2 resid kept", d, 16'd4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule